// File: doc/BRIEF.md
# Video Timing-Reference Word Framer

This block sits behind a serial receiver whose line code and scrambling have already been removed. It takes one data bit per clock. It hunts for the three-word timing reference that marks each video line and uses it to fix where 10-bit words begin. From then on it delivers one parallel word every ten clocks, together with a one-cycle valid strobe. The strobe stands in for a separate parallel clock, so everything runs in the one serial clock domain.

Each accepted reference flips a level output. Downstream timing logic watches for that flip, not for the level. A one-cycle error pulse reports references that are missing or that land off the established word grid. The pulse is meant to feed a rate monitor.

A flywheel input decides how the framer responds to a reference found off the grid. When the flywheel is off, the framer moves its word boundary at once. When it is on, the framer lets one isolated stray reference pass and keeps its timing. It moves only if the next reference is misplaced as well.

Top module: `trs_deser`

## Requirements
- R1: The framer keeps the last 30 received bits. It recognises a reference when those bits, oldest first, are ten ones followed by twenty zeros, i.e. word 3FF hex then two words 000 hex.
- R2: Bits arrive least significant first. The first bit received of a word becomes `par_word[0]` and the last becomes `par_word[9]`, the MSB; an 8-bit source occupies bits 9 to 2. `word_vld` pulses for one cycle per word, and `par_word` changes only in a cycle where `word_vld` is high.
- R3: With `fly_en` low, a reference found off the current word grid moves the grid at once. A word strobe is issued for it, and the following strobes come every ten cycles from there.
- R4: With `fly_en` high and the framer locked, the first off-grid reference is ignored and the old grid is kept. A second off-grid reference, with no on-grid reference between them, moves the grid. An on-grid reference clears the pending state.
- R5: `hsync` inverts exactly once for each accepted reference, that is, each on-grid or grid-moving one, and the inversion coincides with a `word_vld` pulse.
- R6: After `hsync` inverts, the next `word_vld` pulse carries 3FF hex on `par_word`. The flip therefore leads the first reference word by one word period.
- R7: Once locked, every off-grid reference, whether ignored or grid-moving, produces a one-cycle `sync_err` pulse.
- R8: Once locked, if `LINE_WORDS` word strobes pass with no accepted reference, `sync_err` pulses at the last of them and the count restarts.
- R9: Until the first reference after reset, `sync_err` stays low, and the first reference sets the grid whatever its position and whatever `fly_en` is.
- R10: While `rst_n` is low at a clock edge, all outputs go to 0, lock and pending state clear, and the first `word_vld` comes ten cycles after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ser_bit | input | 1 | Descrambled serial data, one bit per clock |
| fly_en | input | 1 | High: tolerate one isolated off-grid reference |
| par_word | output | 10 | Framed parallel word, bit 9 MSB |
| word_vld | output | 1 | One-cycle strobe per parallel word |
| hsync | output | 1 | Inverts once per accepted reference |
| sync_err | output | 1 | One-cycle pulse on missing or off-grid reference |

## Verification
The hardest state to reach is the flywheel's pending state, and then showing that it is cleared. The stimulus inserts four stray bits between lines with the flywheel on, so the next reference lands off-grid and is ignored. Six more stray bits restore the original alignment, and the reference that follows is accepted. A further four-bit slip then has to be ignored again rather than realigning at once. Missing-reference errors are provoked by streaming data words that contain no reference, and lock clearing is shown by a reset followed by the same reference-free data.

// File: rtl/trs_deser_pkg.sv
// Shared definitions for the timing-reference word framer.
package trs_deser_pkg;
    // Default geometry of the framer.
    localparam int DEF_WORD_W     = 10;
    localparam int DEF_SYNC_WORDS = 3;
    localparam int DEF_LINE_WORDS = 1716;

    // Classification of a reference found in the window this cycle.
    typedef enum logic [1:0] {
        SC_NONE    = 2'd0,
        SC_ALIGNED = 2'd1,
        SC_REALIGN = 2'd2,
        SC_IGNORED = 2'd3
    } sync_cls_e;
endpackage

// File: rtl/trs_sync_window.sv
// Bit window and reference detector.
// Shifts each serial bit in at the top of a window of SYNC_WORDS words, so
// that the oldest bit sits at position 0. It flags a match when the oldest
// word is all ones and every later word is all zeros.
// Assumes the bits are already descrambled and arrive LSB first.
module trs_sync_window #(
    parameter int WORD_W     = 10,
    parameter int SYNC_WORDS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_bit,
    output logic [WORD_W-1:0] oldest_word,
    output logic              sync_hit
);
    localparam int WIN_W = WORD_W * SYNC_WORDS;

    logic [WIN_W-1:0] win;
    logic [WIN_W-1:0] pattern;

    // Reference pattern: the leading word is all ones, the rest all zeros.
    for (genvar w = 0; w < SYNC_WORDS; w++) begin : g_pat
        assign pattern[w*WORD_W +: WORD_W] = (w == 0) ? {WORD_W{1'b1}} : {WORD_W{1'b0}};
    end

    // Shift register: the newest bit enters at the top, the oldest leaves at bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win <= '0;
        end else begin
            win <= {ser_bit, win[WIN_W-1:1]};
        end
    end

    assign oldest_word = win[WORD_W-1:0];
    assign sync_hit    = (win == pattern);
endmodule

// File: rtl/trs_align_ctrl.sv
// Word-grid timing and flywheel.
// A modulo-WORD_W phase counter marks the word grid. A reference found on
// the grid is accepted. An off-grid reference moves the grid when the
// framer is unlocked, when the flywheel is off, or when a stray reference
// is already pending; otherwise it is ignored and marked pending. A word
// counter reports a missing reference after LINE_WORDS words.
// Assumes sync_hit is derived from registered window state.
module trs_align_ctrl
    import trs_deser_pkg::*;
#(
    parameter int WORD_W     = 10,
    parameter int LINE_WORDS = 1716
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_hit,
    input  logic fly_en,
    output logic word_stb,
    output logic sync_take,
    output logic err_now
);
    localparam int PH_W  = $clog2(WORD_W);
    localparam int CNT_W = $clog2(LINE_WORDS + 1);
    localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LINE_WORDS - 1);

    logic [PH_W-1:0]  ph;
    logic [CNT_W-1:0] cnt;
    logic             pending;
    logic             locked;
    logic             at_bound;
    logic             miss;
    logic             off_err;
    sync_cls_e        cls;

    // Classify the reference seen this cycle against the grid and lock state.
    always_comb begin
        at_bound = (ph == PH_LAST);
        cls      = SC_NONE;
        if (sync_hit) begin
            if (at_bound) begin
                cls = SC_ALIGNED;
            end else if (!locked || !fly_en || pending) begin
                cls = SC_REALIGN;
            end else begin
                cls = SC_IGNORED;
            end
        end
    end

    assign sync_take = (cls == SC_ALIGNED) || (cls == SC_REALIGN);
    assign word_stb  = at_bound || (cls == SC_REALIGN);
    assign miss      = locked && word_stb && !sync_take && (cnt == CNT_LAST);
    assign off_err   = locked && ((cls == SC_REALIGN) || (cls == SC_IGNORED));
    assign err_now   = miss || off_err;

    // Phase counter: restarts on every word strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph <= '0;
        end else if (word_stb) begin
            ph <= '0;
        end else begin
            ph <= ph + 1'b1;
        end
    end

    // Flywheel pending flag and lock flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
            locked  <= 1'b0;
        end else begin
            if (sync_take) begin
                pending <= 1'b0;
                locked  <= 1'b1;
            end else if (cls == SC_IGNORED) begin
                pending <= 1'b1;
            end
        end
    end

    // Words since the last accepted reference, for the missing-reference check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (sync_take) begin
            cnt <= '0;
        end else if (word_stb) begin
            cnt <= (cnt == CNT_LAST) ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/trs_word_out.sv
// Output stage.
// Holds one word in a staging register, so that the output trails the
// detector by one word. This lets the hsync flip lead the reference word
// by one word period. Registers the strobe, the error pulse and the hsync
// level.
// Assumes sync_take only occurs together with word_stb.
module trs_word_out #(
    parameter int WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_stb,
    input  logic              sync_take,
    input  logic              err_now,
    input  logic [WORD_W-1:0] oldest_word,
    output logic [WORD_W-1:0] par_word,
    output logic              word_vld,
    output logic              hsync,
    output logic              sync_err
);
    logic [WORD_W-1:0] stage;

    // Two-stage word pipeline advanced by the word strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage    <= '0;
            par_word <= '0;
        end else if (word_stb) begin
            stage    <= oldest_word;
            par_word <= stage;
        end
    end

    // Registered strobe, error pulse and hsync level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_vld <= 1'b0;
            sync_err <= 1'b0;
            hsync    <= 1'b0;
        end else begin
            word_vld <= word_stb;
            sync_err <= err_now;
            if (sync_take) begin
                hsync <= ~hsync;
            end
        end
    end
endmodule

// File: rtl/trs_deser.sv
// Timing-reference framed serial-to-parallel converter (top).
// Connects the bit window, the grid and flywheel control and the output
// stage. It works in one clock domain, one serial bit per clock.
module trs_deser
    import trs_deser_pkg::*;
#(
    parameter int WORD_W     = DEF_WORD_W,
    parameter int SYNC_WORDS = DEF_SYNC_WORDS,
    parameter int LINE_WORDS = DEF_LINE_WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_bit,
    input  logic              fly_en,
    output logic [WORD_W-1:0] par_word,
    output logic              word_vld,
    output logic              hsync,
    output logic              sync_err
);
    logic [WORD_W-1:0] oldest_word;
    logic              sync_hit;
    logic              word_stb;
    logic              sync_take;
    logic              err_now;

    trs_sync_window #(.WORD_W(WORD_W), .SYNC_WORDS(SYNC_WORDS)) u_win (
        .clk(clk), .rst_n(rst_n), .ser_bit(ser_bit),
        .oldest_word(oldest_word), .sync_hit(sync_hit)
    );

    trs_align_ctrl #(.WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .sync_hit(sync_hit), .fly_en(fly_en),
        .word_stb(word_stb), .sync_take(sync_take), .err_now(err_now)
    );

    trs_word_out #(.WORD_W(WORD_W)) u_out (
        .clk(clk), .rst_n(rst_n), .word_stb(word_stb), .sync_take(sync_take),
        .err_now(err_now), .oldest_word(oldest_word),
        .par_word(par_word), .word_vld(word_vld), .hsync(hsync), .sync_err(sync_err)
    );
endmodule

// File: rtl/trs_deser_chk.sv
// Port-level property checker for trs_deser, bound to every instance.
// It keeps a gap counter, a previous-hsync register, an armed flag and a
// sticky seen-a-reference flag.
module trs_deser_chk #(
    parameter int WORD_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic [WORD_W-1:0] par_word,
    input logic              word_vld,
    input logic              hsync,
    input logic              sync_err
);
    localparam int GAP_W = $clog2(WORD_W + 2);
    localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(WORD_W);

    logic [GAP_W-1:0] gap_q;
    logic             hs_q;
    logic             armed_q;
    logic             seen_q;

    // Observation state: cycles since the last strobe and hsync history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q   <= '0;
            hs_q    <= 1'b0;
            armed_q <= 1'b0;
            seen_q  <= 1'b0;
        end else begin
            gap_q <= word_vld ? '0 : gap_q + 1'b1;
            hs_q  <= hsync;
            if (hsync != hs_q) begin
                armed_q <= 1'b1;
                seen_q  <= 1'b1;
            end else if (word_vld) begin
                armed_q <= 1'b0;
            end
        end
    end

    // R2: strobes are never more than WORD_W cycles apart
    p_vld_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_q >= GAP_MAX) |-> word_vld);

    // R2: the word holds between strobes
    p_word_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !word_vld |-> $stable(par_word));

    // R5: hsync flips only with a strobe
    p_hsync_on_vld_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(hsync) |-> word_vld);

    // R6: the strobe after an hsync flip carries the all-ones reference word
    p_lead_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld && armed_q && (hsync == hs_q)) |-> (par_word == {WORD_W{1'b1}}));

    // R9: no error before the first accepted reference
    p_quiet_unlocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sync_err |-> seen_q);
endmodule

bind trs_deser trs_deser_chk #(.WORD_W(WORD_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .par_word(par_word), .word_vld(word_vld),
    .hsync(hsync), .sync_err(sync_err)
);

// File: tb/trs_deser_test.sv
// Self-checking bench: a behavioural reference model compared on every clock,
// plus directed checks on event counts.
module trs_deser_test;
    localparam int WW  = 10;
    localparam int LW  = 8;
    localparam int WIN = 30;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ser_bit = 1'b0;
    logic          fly_en = 1'b0;
    logic [WW-1:0] par_word;
    logic          word_vld;
    logic          hsync;
    logic          sync_err;

    always #10 clk = ~clk;

    trs_deser #(.WORD_W(WW), .LINE_WORDS(LW)) uut (
        .clk(clk), .rst_n(rst_n), .ser_bit(ser_bit), .fly_en(fly_en),
        .par_word(par_word), .word_vld(word_vld), .hsync(hsync), .sync_err(sync_err)
    );

    int n_chk = 0;
    int n_bad = 0;
    int n_tog = 0;
    int n_err = 0;
    int cyc = 0;
    bit done = 0;
    bit armed = 0;
    logic prev_hs = 1'b0;

    // reference model state
    bit            hist[$];
    int            m_ph = 0;
    bit            m_pend = 0;
    bit            m_lock = 0;
    int            m_cnt = 0;
    logic [WW-1:0] m_hold = '0;
    logic [WW-1:0] e_word = '0;
    bit            e_vld = 0;
    bit            e_hs = 0;
    bit            e_err = 0;

    task automatic check(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    // One clock of the model, applied with the inputs seen at the last edge.
    task automatic model_step(bit b, bit rn, bit fe);
        bit sync;
        bit atb;
        bit realign;
        bit ignore;
        bit take;
        bit stb;
        bit miss;
        bit err;
        logic [WW-1:0] lsw;
        if (!rn) begin
            hist.delete();
            repeat (WIN) hist.push_back(1'b0);
            m_ph = 0; m_pend = 0; m_lock = 0; m_cnt = 0;
            m_hold = '0; e_word = '0; e_vld = 0; e_hs = 0; e_err = 0;
            return;
        end
        sync = 1;
        for (int i = 0; i < WIN; i++) if (hist[i] != (i < WW)) sync = 0;
        atb     = (m_ph == WW - 1);
        realign = sync && !atb && (!m_lock || !fe || m_pend);
        ignore  = sync && !atb && !realign;
        take    = (sync && atb) || realign;
        stb     = atb || realign;
        miss    = m_lock && stb && !take && (m_cnt == LW - 1);
        err     = miss || (m_lock && sync && !atb);
        for (int i = 0; i < WW; i++) lsw[i] = hist[i];
        e_vld = stb;
        e_err = err;
        if (stb) begin
            e_word = m_hold;
            m_hold = lsw;
        end
        if (take) e_hs = !e_hs;
        m_ph = stb ? 0 : m_ph + 1;
        if (take) m_pend = 0;
        else if (ignore) m_pend = 1;
        if (take) m_lock = 1;
        if (take) m_cnt = 0;
        else if (stb) m_cnt = (m_cnt == LW - 1) ? 0 : m_cnt + 1;
        void'(hist.pop_front());
        hist.push_back(b);
    endtask

    // Per-clock comparison against the model, event counting and watchdog.
    always @(negedge clk) begin
        if (!done) begin
            cyc++;
            model_step(ser_bit, rst_n, fly_en);
            check(par_word === e_word, "R2 parallel word", int'(par_word), int'(e_word));
            check(word_vld === e_vld, "R2 word strobe", int'(word_vld), int'(e_vld));
            check(hsync === e_hs, "R5 hsync level", int'(hsync), int'(e_hs));
            check(sync_err === e_err, "R7 sync_err", int'(sync_err), int'(e_err));
            if (!rst_n) begin
                armed = 0;
            end else begin
                if (hsync !== prev_hs) n_tog++;
                if (sync_err === 1'b1) n_err++;
                if (word_vld && armed && (hsync === prev_hs)) begin
                    check(par_word == 10'h3FF, "R6 word after hsync flip", int'(par_word), 'h3FF);
                    armed = 0;
                end
                if (hsync !== prev_hs) armed = 1;
            end
            prev_hs = hsync;
            if (cyc > 100000) begin
                n_bad++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
                finish_run();
            end
        end
    end

    task automatic put_bit(bit b);
        @(negedge clk);
        #1 ser_bit = b;
    endtask

    task automatic put_word(logic [WW-1:0] w);
        for (int i = 0; i < WW; i++) put_bit(w[i]);
    endtask

    // Nonzero data word that is never all ones, so no false reference forms.
    function automatic logic [WW-1:0] rand_word();
        return WW'($urandom_range(1, 1021));
    endfunction

    task automatic put_line();
        put_word(10'h3FF);
        put_word(10'h000);
        put_word(10'h000);
        put_word(10'h2A5);
        for (int i = 0; i < LW - 4; i++) put_word(rand_word());
    endtask

    int t0;
    int e0;

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check(par_word == 0 && !word_vld && !hsync && !sync_err, "R10 outputs in reset",
              int'({par_word, word_vld, hsync, sync_err}), 0);
        #1 rst_n = 1'b1;

        // R9, R1: acquisition of an off-grid first reference
        repeat (3) put_bit(1'b0);
        t0 = n_tog; e0 = n_err;
        put_line();
        put_line();
        check(n_tog - t0 == 2, "R1 references detected", n_tog - t0, 2);
        check(n_err - e0 == 0, "R9 no error during acquisition", n_err - e0, 0);

        // R3: flywheel off, a slipped reference moves the grid
        fly_en = 1'b0;
        t0 = n_tog; e0 = n_err;
        repeat (4) put_bit(1'b0);
        put_line();
        check(n_tog - t0 == 1, "R3 slipped reference accepted", n_tog - t0, 1);
        check(n_err - e0 >= 1, "R7 error on slipped reference", n_err - e0, 1);
        e0 = n_err;
        put_line();
        check(n_err - e0 == 0, "R3 new grid held", n_err - e0, 0);

        // R4: flywheel on
        fly_en = 1'b1;
        put_line();
        t0 = n_tog; e0 = n_err;
        repeat (4) put_bit(1'b0);
        put_line();
        check(n_tog - t0 == 0, "R4 isolated slip ignored", n_tog - t0, 0);
        check(n_err - e0 >= 1, "R7 error on ignored slip", n_err - e0, 1);
        t0 = n_tog;
        repeat (6) put_bit(1'b0);
        put_line();
        check(n_tog - t0 == 1, "R4 on-grid reference accepted", n_tog - t0, 1);
        t0 = n_tog;
        repeat (4) put_bit(1'b0);
        put_line();
        check(n_tog - t0 == 0, "R4 pending cleared so slip ignored again", n_tog - t0, 0);
        t0 = n_tog; e0 = n_err;
        put_line();
        check(n_tog - t0 == 1, "R4 second slip realigns", n_tog - t0, 1);
        check(n_err - e0 >= 1, "R7 error on realigning slip", n_err - e0, 1);
        e0 = n_err;
        put_line();
        check(n_err - e0 == 0, "R4 grid stable after realign", n_err - e0, 0);

        // R8: missing references
        fly_en = 1'b0;
        e0 = n_err;
        repeat (20) put_word(rand_word());
        check(n_err - e0 >= 2, "R8 missing reference errors", n_err - e0, 2);

        // R10, R9: reset mid-stream clears lock
        rst_n = 1'b0;
        put_bit(1'b0);
        put_bit(1'b0);
        check(par_word == 0 && !word_vld && !hsync && !sync_err, "R10 outputs after reset",
              int'({par_word, word_vld, hsync, sync_err}), 0);
        rst_n = 1'b1;
        e0 = n_err;
        repeat (20) put_word(rand_word());
        check(n_err - e0 == 0, "R9 no error while unlocked", n_err - e0, 0);
        t0 = n_tog;
        put_line();
        put_line();
        check(n_tog - t0 == 2, "R1 reacquired after reset", n_tog - t0, 2);
        check(n_err - e0 == 0, "R9 reacquisition without error", n_err - e0, 0);

        repeat (25) put_bit(1'b0);
        finish_run();
    end
endmodule